// File: doc/BRIEF.md
# Compare and Test Flag Unit

This block evaluates a pair of operands and produces a set of six status flags without ever keeping the arithmetic result. Two evaluation kinds are offered. A bitwise test ANDs the operands. A compare subtracts the second operand from the first. The flags (carry, overflow, sign, zero, auxiliary borrow and parity) are formed from the internal result, which is then dropped. The flags are latched into a register when a valid strobe is present.

A runtime size select picks an 8, 16 or 32 bit view of the operands. Bits above the chosen size take no part in any flag. The second operand can instead be taken from a short field of `IMM_W` bits, sign-extended to the chosen size. A surrounding datapath issues one evaluation per strobe and reads the registered flags on the following cycle.

Top module: `flag_eval_unit`

## Requirements
- R1: With `op_cmp`=0 (test), the internal result is the AND of the sized first operand and the sized second operand, and SF, ZF and PF are formed from it.
- R2: After a test, `flag_c`, `flag_o` and `flag_a` are all 0, whatever the operands.
- R3: `flag_s` is the top bit of the result at the selected size, where `size_sel` 0 means 8 bits, 1 means 16 bits, and 2 or 3 means 32 bits.
- R4: `flag_z` is 1 exactly when every result bit within the selected size is zero.
- R5: `flag_p` is 1 when result bits 7..0 hold an even number of ones; no higher bit affects it.
- R6: With `op_cmp`=1 (compare), the result is first operand minus second operand, and `flag_c` is 1 exactly when the sized first operand is below the sized second operand as unsigned values. Equal operands give ZF=1 and CF=0.
- R7: In a compare, `flag_o` is 1 when the operand sign bits differ and the result sign bit differs from the first operand's sign bit.
- R8: In a compare, `flag_a` is 1 when the low nibble of the first operand is below the low nibble of the second (borrow out of bit 3).
- R9: With `src2_short`=1, the second operand is `b_in[IMM_W-1:0]` sign-extended to the selected size; with 0, `b_in` is used at the selected size.
- R10: The flag register loads on a rising edge only while `valid` is 1 and holds its value otherwise.
- R11: A synchronous `rst` clears all six flags to 0 and takes priority over `valid`.
- R12: Bits of `a_in` and `b_in` above the selected size have no effect on any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| valid | input | 1 | Load strobe for the flag register |
| op_cmp | input | 1 | 0 = bitwise test, 1 = subtract compare |
| size_sel | input | 2 | Operand size: 0 = 8, 1 = 16, 2/3 = 32 bits |
| src2_short | input | 1 | Take second operand from the short field, sign-extended |
| a_in | input | DATA_W | First operand |
| b_in | input | DATA_W | Second operand |
| flag_c | output | 1 | Carry / borrow flag |
| flag_o | output | 1 | Signed overflow flag |
| flag_s | output | 1 | Sign flag |
| flag_z | output | 1 | Zero flag |
| flag_a | output | 1 | Auxiliary borrow out of bit 3 |
| flag_p | output | 1 | Even parity of the low result byte |

## Verification
The block has no state other than the six flag bits. So a wrong mask, a wrong sign-extension bit or a wrong borrow tap shows up at the flag outputs on the first edge after the offending strobe. Any such error gives a wrong flag value on the next cycle. A register that fails to hold or to clear shows as a flag that changes on a cycle without `valid`, or that is non-zero right after reset. The bench compares all six flags against its own model on every cycle, so a fault is caught one cycle after it occurs.

// File: rtl/flagu_pkg.sv
package flagu_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } size_e;

  typedef struct packed {
    logic cf;
    logic of;
    logic sf;
    logic zf;
    logic af;
    logic pf;
  } flags_t;

  // number of bits an operand occupies for a given size code
  function automatic int size_bits(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: size_bits = 8;
      SZ_HALF: size_bits = 16;
      default: size_bits = 32;
    endcase
  endfunction

  // 1 when the byte has an even count of ones
  function automatic logic even_ones8(input logic [7:0] v);
    even_ones8 = ~(^v);
  endfunction

endpackage

// File: rtl/flagu_src2_ext.sv
module flagu_src2_ext #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8
) (
  input  logic [DATA_W-1:0] b_raw,
  input  logic              use_short,
  input  logic [DATA_W-1:0] size_mask,
  output logic [DATA_W-1:0] src2_sized
);
  localparam int FILL_W = DATA_W - IMM_W;

  logic              short_sign;
  logic [DATA_W-1:0] short_ext;

  assign short_sign = b_raw[IMM_W-1];

  generate
    if (FILL_W > 0) begin : g_fill
      assign short_ext = {{FILL_W{short_sign}}, b_raw[IMM_W-1:0]};
    end else begin : g_nofill
      assign short_ext = b_raw;
    end
  endgenerate

  assign src2_sized = (use_short ? short_ext : b_raw) & size_mask;

endmodule

// File: rtl/flagu_compute.sv
module flagu_compute
  import flagu_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic              is_cmp,
  input  logic [IDX_W-1:0]  msb_idx,
  input  logic [DATA_W-1:0] size_mask,
  output flags_t            flags_nxt,
  output logic [DATA_W-1:0] result_w,
  output logic              nibble_borrow,
  output logic              full_borrow
);

  // subtract with one extra bit so the borrow lands on top
  function automatic logic [DATA_W:0] sub_ext(input logic [DATA_W-1:0] x,
                                              input logic [DATA_W-1:0] y);
    sub_ext = {1'b0, x} - {1'b0, y};
  endfunction

  // signed overflow of x - y judged at bit k
  function automatic logic sub_ovf(input logic xs, input logic ys, input logic rs);
    sub_ovf = (xs ^ ys) & (rs ^ xs);
  endfunction

  logic [DATA_W:0]   diff_ext;
  logic [DATA_W-1:0] and_res;
  logic              res_top;

  assign diff_ext      = sub_ext(opa, opb);
  assign and_res       = opa & opb;
  assign result_w      = (is_cmp ? diff_ext[DATA_W-1:0] : and_res) & size_mask;
  assign res_top       = result_w[msb_idx];
  // operands are already sized, so the top borrow is the size-level borrow
  assign full_borrow   = diff_ext[DATA_W];
  assign nibble_borrow = opa[4] ^ opb[4] ^ diff_ext[4];

  always_comb begin
    flags_nxt.sf = res_top;
    flags_nxt.zf = (result_w == '0);
    flags_nxt.pf = even_ones8(result_w[7:0]);
    if (is_cmp) begin
      flags_nxt.cf = full_borrow;
      flags_nxt.of = sub_ovf(opa[msb_idx], opb[msb_idx], res_top);
      flags_nxt.af = nibble_borrow;
    end else begin
      flags_nxt.cf = 1'b0;
      flags_nxt.of = 1'b0;
      flags_nxt.af = 1'b0;
    end
  end

  // a zero result can never look negative (R4 with R3)
  always_comb begin
    assert_zero_not_neg_R4: assert (!(flags_nxt.zf && flags_nxt.sf));
  end

endmodule

// File: rtl/flagu_hold_reg.sv
module flagu_hold_reg
  import flagu_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   load,
  input  flags_t d,
  output flags_t q
);

  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(q));

  assert_load_R10: assert property (@(posedge clk) disable iff (rst)
    load |=> (q == $past(d)));

endmodule

// File: rtl/flag_eval_unit.sv
module flag_eval_unit
  import flagu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic              op_cmp,
  input  logic [1:0]        size_sel,
  input  logic              src2_short,
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] b_in,
  output logic              flag_c,
  output logic              flag_o,
  output logic              flag_s,
  output logic              flag_z,
  output logic              flag_a,
  output logic              flag_p
);

  function automatic int eff_bits(input logic [1:0] sz);
    int n;
    n = size_bits(sz);
    eff_bits = (n > DATA_W) ? DATA_W : n;
  endfunction

  logic [DATA_W-1:0] size_mask;
  logic [IDX_W-1:0]  msb_idx;
  logic [DATA_W-1:0] a_sized;
  logic [DATA_W-1:0] src2_sized;
  logic [DATA_W-1:0] result_w;
  logic              nibble_borrow;
  logic              full_borrow;
  flags_t            flags_nxt;
  flags_t            flags_q;

  assign msb_idx = IDX_W'(eff_bits(size_sel) - 1);

  generate
    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
      assign size_mask[i] = (i < eff_bits(size_sel));
    end
  endgenerate

  assign a_sized = a_in & size_mask;

  flagu_src2_ext #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_ext (
    .b_raw      (b_in),
    .use_short  (src2_short),
    .size_mask  (size_mask),
    .src2_sized (src2_sized)
  );

  flagu_compute #(.DATA_W(DATA_W)) u_comp (
    .opa           (a_sized),
    .opb           (src2_sized),
    .is_cmp        (op_cmp),
    .msb_idx       (msb_idx),
    .size_mask     (size_mask),
    .flags_nxt     (flags_nxt),
    .result_w      (result_w),
    .nibble_borrow (nibble_borrow),
    .full_borrow   (full_borrow)
  );

  flagu_hold_reg u_reg (
    .clk  (clk),
    .rst  (rst),
    .load (valid),
    .d    (flags_nxt),
    .q    (flags_q)
  );

  assign flag_c = flags_q.cf;
  assign flag_o = flags_q.of;
  assign flag_s = flags_q.sf;
  assign flag_z = flags_q.zf;
  assign flag_a = flags_q.af;
  assign flag_p = flags_q.pf;

  assert_test_clears_R2: assert property (@(posedge clk) disable iff (rst)
    (valid && !op_cmp) |=> (!flag_c && !flag_o && !flag_a));

  assert_cmp_equal_R6: assert property (@(posedge clk) disable iff (rst)
    (valid && op_cmp && (a_sized == src2_sized)) |=> (flag_z && !flag_c));

  assert_cmp_below_R6: assert property (@(posedge clk) disable iff (rst)
    (valid && op_cmp && (a_sized < src2_sized)) |=> (flag_c && !flag_z));

  assert_sext_fill_R9: assert property (@(posedge clk) disable iff (rst)
    (src2_short && (eff_bits(size_sel) > IMM_W)) |->
      (src2_sized[msb_idx] == b_in[IMM_W-1]));

  assert_result_sized_R12: assert property (@(posedge clk) disable iff (rst)
    (result_w & ~size_mask) == '0);

endmodule

// File: tb/flag_eval_unit_bench.sv
module flag_eval_unit_bench;
  localparam int DW = 32;
  localparam int IW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          valid = 1'b0;
  logic          op_cmp = 1'b0;
  logic [1:0]    size_sel = 2'd0;
  logic          src2_short = 1'b0;
  logic [DW-1:0] a_in = '0;
  logic [DW-1:0] b_in = '0;
  logic flag_c, flag_o, flag_s, flag_z, flag_a, flag_p;

  int total = 0;
  int bad   = 0;
  logic [5:0] expv = 6'd0;  // {c,o,s,z,a,p}

  always #2 clk = ~clk;

  flag_eval_unit #(.DATA_W(DW), .IMM_W(IW)) u_flag_eval_unit (
    .clk(clk), .rst(rst), .valid(valid), .op_cmp(op_cmp), .size_sel(size_sel),
    .src2_short(src2_short), .a_in(a_in), .b_in(b_in),
    .flag_c(flag_c), .flag_o(flag_o), .flag_s(flag_s), .flag_z(flag_z),
    .flag_a(flag_a), .flag_p(flag_p)
  );

  // behavioural reference: plain integer arithmetic
  function automatic logic [5:0] model(input logic cmp, input logic [1:0] sz,
                                       input logic shrt, input logic [31:0] a,
                                       input logic [31:0] b);
    longint w, m, av, bv, r, sa, sb, d, half;
    int ones;
    logic c, o, s, z, af, p;
    w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    m = (64'sd1 <<< w) - 1;
    av = longint'(a) & m;
    if (shrt) begin
      bv = longint'(b & 32'hFF);
      if (bv >= 128) bv = bv - 256;
      bv = bv & m;
    end else bv = longint'(b) & m;
    c = 0; o = 0; af = 0;
    if (cmp) begin
      r = (av - bv) & m;
      c = (av < bv);
      half = 64'sd1 <<< (w - 1);
      sa = (av >= half) ? av - 2 * half : av;
      sb = (bv >= half) ? bv - 2 * half : bv;
      d = sa - sb;
      o = (d >= half) || (d < -half);
      af = ((av & 15) < (bv & 15));
    end else r = av & bv;
    s = ((r >>> (w - 1)) & 1) != 0;
    z = (r == 0);
    ones = 0;
    for (int i = 0; i < 8; i++) if (((r >>> i) & 1) != 0) ones++;
    p = (ones % 2) == 0;
    return {c, o, s, z, af, p};
  endfunction

  task automatic check(input string tag);
    logic [5:0] act;
    act = {flag_c, flag_o, flag_s, flag_z, flag_a, flag_p};
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s: flags(c,o,s,z,a,p) actual=%b expected=%b", tag, act, expv);
    end
  endtask

  // drive at a negedge, model at the edge, compare at the next negedge
  task automatic step(input logic r, input logic v, input logic cmp,
                      input logic [1:0] sz, input logic shrt,
                      input logic [31:0] a, input logic [31:0] b, input string tag);
    rst = r; valid = v; op_cmp = cmp; size_sel = sz; src2_short = shrt;
    a_in = a; b_in = b;
    @(posedge clk);
    if (r) expv = 6'd0;
    else if (v) expv = model(cmp, sz, shrt, a, b);
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL R10 watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    step(1, 1, 1, 0, 0, 32'h1, 32'h2, "R11 reset state");
    // test mode
    step(0, 1, 0, 0, 0, 32'hF0, 32'h3C, "R1 test and");
    step(0, 1, 0, 0, 0, 32'hAA, 32'h55, "R4 test zero");
    step(0, 1, 0, 2, 0, 32'hFFFF_FFFF, 32'h8000_0001, "R2 test clears c/o/a");
    step(0, 1, 0, 1, 0, 32'h0000_8000, 32'h0000_FFFF, "R3 test sign 16");
    step(0, 1, 0, 2, 0, 32'h0000_0300, 32'h0000_0F00, "R5 parity low byte only");
    step(0, 1, 0, 0, 0, 32'h07, 32'h07, "R5 odd parity");
    // compare mode
    step(0, 1, 1, 0, 0, 32'h42, 32'h42, "R6 equal");
    step(0, 1, 1, 0, 0, 32'h10, 32'h20, "R6 below");
    step(0, 1, 1, 0, 0, 32'h90, 32'h20, "R6 above");
    step(0, 1, 1, 0, 0, 32'h80, 32'h01, "R7 overflow 8");
    step(0, 1, 1, 1, 0, 32'h7FFF, 32'hFFFF, "R7 overflow 16");
    step(0, 1, 1, 2, 0, 32'h8000_0000, 32'h0000_0001, "R7 overflow 32");
    step(0, 1, 1, 0, 0, 32'h13, 32'h05, "R8 nibble borrow");
    step(0, 1, 1, 0, 0, 32'h35, 32'h13, "R8 no nibble borrow");
    step(0, 1, 1, 3, 0, 32'h0000_0000, 32'h0000_0001, "R3 size 3 as 32");
    // short second operand
    step(0, 1, 1, 2, 1, 32'hFFFF_FFFF, 32'h1234_56FF, "R9 short neg ext 32");
    step(0, 1, 1, 1, 1, 32'h0000_007F, 32'hABCD_007F, "R9 short pos ext 16");
    step(0, 1, 0, 1, 1, 32'h0000_8000, 32'h0000_0080, "R9 short test ext");
    step(0, 1, 1, 2, 0, 32'h0000_00FF, 32'h1234_56FF, "R9 full operand");
    // upper bits ignored
    step(0, 1, 0, 0, 0, 32'hFFFF_FF00, 32'hFFFF_FFFF, "R12 upper a ignored");
    step(0, 1, 1, 0, 0, 32'hABCD_EF05, 32'h1234_5605, "R12 upper both ignored");
    step(0, 1, 1, 1, 0, 32'h1111_0001, 32'h2222_0002, "R12 upper 16 ignored");
    // hold
    step(0, 1, 1, 0, 0, 32'h00, 32'h01, "R10 load before hold");
    step(0, 0, 0, 0, 0, 32'h01, 32'h01, "R10 hold no valid");
    step(0, 0, 1, 2, 1, 32'h00, 32'h00, "R10 hold again");
    // reset priority
    step(1, 1, 1, 0, 0, 32'h00, 32'h01, "R11 reset over valid");
    step(0, 0, 1, 0, 0, 32'h00, 32'h01, "R11 cleared hold");
    // random mix against the model
    for (int k = 0; k < 400; k++) begin
      logic v, cmp, shrt;
      logic [1:0] sz;
      logic [31:0] a, b;
      v = ($urandom % 4) != 0;
      cmp = $urandom % 2;
      shrt = $urandom % 2;
      sz = 2'($urandom % 4);
      a = $urandom;
      b = $urandom;
      if (k % 7 == 0) b = a;
      step(0, v, cmp, sz, shrt, a, b, cmp ? "R6 random compare" : "R1 random test");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule